// File: doc/BRIEF.md
# Doorbell Signal Interrupt Controller

This block lets processors notify one another through doorbells. Each doorbell is named by a 32-bit word that packs a client number and a signal number. A local register bus write of such a word to the ring register marks that doorbell as pending. A second ring input carries doorbells that other processors raise. The receiving side keeps one pending flag and one enable flag per doorbell. It raises a single active-high level interrupt while any enabled doorbell is pending.

The receiving software reads the fetch register in a loop. Each read returns the lowest-numbered doorbell that is both pending and enabled. Software acknowledges that doorbell by writing its identifier to the acknowledge register, then reads again. An all-ones value means nothing is left to service. Separate registers unmask and mask one doorbell at a time, again by identifier. The number of clients and signals per client are parameters; the default is 4 clients of 12 signals, which gives 48 doorbells.

Top module: `db_ctrl`

## Requirements
- R1: An identifier word carries the client number in bits [31:16] and the signal number in bits [15:0]. The fetch register returns the identifier in the same packing.
- R2: The fetch register is at offset 0x10 and is read with no wait state. It returns the enabled, pending doorbell with the lowest client number, and within that client the lowest signal number.
- R3: A read of offset 0x10 returns 0xFFFFFFFF when no enabled doorbell is pending. A read of any other offset returns zero.
- R4: A write to offset 0x14 enables the addressed doorbell, and a write to offset 0x18 masks it. A masked doorbell still records a ring and is reported once it is enabled again.
- R5: A write to offset 0x1C clears the addressed doorbell's pending flag.
- R6: The irq output is high exactly while at least one doorbell is both pending and enabled. It changes in the cycle after the write that causes the change.
- R7: An identifier whose client is at or above the client count, or whose signal is at or above the per-client signal count, has no effect at any register. Writes to offsets with no register also have no effect.
- R8: If a ring and an acknowledge reach the same doorbell in the same cycle, the doorbell stays pending.
- R9: Reset clears every pending flag and every enable flag, and it drives irq low.
- R10: A write to offset 0x0C, or a cycle with ring_vld high, marks the doorbell named by the write data or by ring_id as pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe for one cycle |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data, a packed identifier |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ring_vld | input | 1 | Ring from a remote processor this cycle |
| ring_id | input | 32 | Packed identifier of that ring |
| irq | output | 1 | Level summary interrupt, active high |

## Verification
A wrong pending or enable flag appears at the ports in the cycle after the write that corrupts it. In that cycle the fetch register returns a different identifier or all-ones where it should not, and irq takes the wrong level. A fault in the priority order only shows when two or more enabled doorbells are pending together. The bench therefore keeps several doorbells pending across clients, and it drains them in a read-and-acknowledge loop. A reference model compares the fetch value and irq on every idle clock, so any divergence is reported within one cycle.

// File: rtl/db_pkg.sv
package db_pkg;

   localparam int ID_W = 32;

   // register byte offsets
   localparam int OFS_RING  = 'h0C;
   localparam int OFS_FETCH = 'h10;
   localparam int OFS_UNMSK = 'h14;
   localparam int OFS_MASK  = 'h18;
   localparam int OFS_ACK   = 'h1C;

   localparam logic [ID_W-1:0] NONE_PENDING = '1;

   typedef struct packed {
      logic [15:0] client;
      logic [15:0] sig;
   } db_id_t;

endpackage

// File: rtl/db_decode.sv
module db_decode
   import db_pkg::*;
#(
   parameter int NC = 4,
   parameter int NS = 12,
   localparam int N = NC * NS
) (
   input  db_id_t         id_i,
   output logic [N-1:0]   onehot_o
);

   // an out-of-range identifier matches no lane, so it yields an all-zero vector
   for (genvar c = 0; c < NC; c++) begin : g_cli
      for (genvar s = 0; s < NS; s++) begin : g_sig
         assign onehot_o[c*NS + s] = (id_i.client == 16'(c)) && (id_i.sig == 16'(s));
      end
   end

endmodule

// File: rtl/db_bank.sv
module db_bank #(
   parameter int N = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ring_i,
   input  logic [N-1:0] ack_i,
   input  logic [N-1:0] unmsk_i,
   input  logic [N-1:0] mask_i,
   output logic [N-1:0] pend_o,
   output logic [N-1:0] en_o
);

   for (genvar i = 0; i < N; i++) begin : g_lane
      // ring has priority over acknowledge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         pend_o[i] <= 1'b0;
         else if (ring_i[i]) pend_o[i] <= 1'b1;
         else if (ack_i[i])  pend_o[i] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          en_o[i] <= 1'b0;
         else if (mask_i[i])  en_o[i] <= 1'b0;
         else if (unmsk_i[i]) en_o[i] <= 1'b1;
      end
   end

endmodule

// File: rtl/db_pick.sv
module db_pick
   import db_pkg::*;
#(
   parameter int NC = 4,
   parameter int NS = 12,
   localparam int N = NC * NS
) (
   input  logic [N-1:0] active_i,
   output logic         found_o,
   output db_id_t       id_o
);

   // scan from the top so the lowest active lane is the last one assigned
   always_comb begin
      found_o = 1'b0;
      id_o    = '0;
      for (int c = NC - 1; c >= 0; c--) begin
         for (int s = NS - 1; s >= 0; s--) begin
            if (active_i[c*NS + s]) begin
               found_o     = 1'b1;
               id_o.client = 16'(c);
               id_o.sig    = 16'(s);
            end
         end
      end
   end

endmodule

// File: rtl/db_ctrl.sv
module db_ctrl
   import db_pkg::*;
#(
   parameter int NC      = 4,
   parameter int NS      = 12,
   parameter int AW      = 8,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   input  logic          ring_vld,
   input  logic [31:0]   ring_id,
   output logic          irq
);

   localparam int N = NC * NS;

   if (NC < 1 || NC > 65535) begin : g_bad_nc
      $error("db_ctrl: NC out of range");
   end
   if (NS < 1 || NS > 65535) begin : g_bad_ns
      $error("db_ctrl: NS out of range");
   end
   if (N > 4096) begin : g_bad_n
      $error("db_ctrl: too many doorbells");
   end
   if (AW < 5) begin : g_bad_aw
      $error("db_ctrl: address too narrow");
   end

   db_id_t       wr_id, rg_id, pick_id;
   logic [N-1:0] wr_oh, rg_oh;
   logic [N-1:0] ring_vec, ack_vec, unmsk_vec, mask_vec;
   logic [N-1:0] pend_q, en_q, active;
   logic         is_ring, is_ack, is_unmsk, is_mask, found, any_act;

   assign wr_id = bus_wdata;
   assign rg_id = ring_id;

   db_decode #(.NC(NC), .NS(NS)) u_dec_bus  (.id_i(wr_id), .onehot_o(wr_oh));
   db_decode #(.NC(NC), .NS(NS)) u_dec_ring (.id_i(rg_id), .onehot_o(rg_oh));

   assign is_ring  = bus_wr && (bus_addr == AW'(OFS_RING));
   assign is_ack   = bus_wr && (bus_addr == AW'(OFS_ACK));
   assign is_unmsk = bus_wr && (bus_addr == AW'(OFS_UNMSK));
   assign is_mask  = bus_wr && (bus_addr == AW'(OFS_MASK));

   assign ring_vec  = ({N{is_ring}} & wr_oh) | ({N{ring_vld}} & rg_oh);
   assign ack_vec   = {N{is_ack}}   & wr_oh;
   assign unmsk_vec = {N{is_unmsk}} & wr_oh;
   assign mask_vec  = {N{is_mask}}  & wr_oh;

   db_bank #(.N(N)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .ring_i  (ring_vec),
      .ack_i   (ack_vec),
      .unmsk_i (unmsk_vec),
      .mask_i  (mask_vec),
      .pend_o  (pend_q),
      .en_o    (en_q)
   );

   assign active  = pend_q & en_q;
   assign any_act = |active;

   db_pick #(.NC(NC), .NS(NS)) u_pick (
      .active_i (active),
      .found_o  (found),
      .id_o     (pick_id)
   );

   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= any_act;
      end
   end else begin : g_irq_comb
      assign irq = any_act;
   end

   always_comb begin
      if (bus_addr == AW'(OFS_FETCH)) bus_rdata = found ? pick_id : NONE_PENDING;
      else                            bus_rdata = '0;
   end

endmodule

// File: rtl/db_ctrl_chk.sv
module db_ctrl_chk
   import db_pkg::*;
#(
   parameter int NC = 4,
   parameter int NS = 12,
   parameter int AW = 8,
   localparam int N = NC * NS
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [AW-1:0] bus_addr,
   input logic [31:0]   bus_wdata,
   input logic [31:0]   bus_rdata,
   input logic          ring_vld,
   input logic [31:0]   ring_id,
   input logic [N-1:0]  pend_q,
   input logic [N-1:0]  en_q
);

   function automatic bit in_rng(logic [31:0] w);
      return (int'(w[31:16]) < NC) && (int'(w[15:0]) < NS);
   endfunction

   function automatic int lane(logic [31:0] w);
      return int'(w[31:16]) * NS + int'(w[15:0]);
   endfunction

   int  wr_idx, rg_idx, rd_idx;
   bit  wr_ok, rg_ok, rd_ok;
   assign wr_idx = in_rng(bus_wdata) ? lane(bus_wdata) : 0;
   assign rg_idx = in_rng(ring_id)   ? lane(ring_id)   : 0;
   assign rd_idx = in_rng(bus_rdata) ? lane(bus_rdata) : 0;
   assign wr_ok  = in_rng(bus_wdata);
   assign rg_ok  = in_rng(ring_id);
   assign rd_ok  = in_rng(bus_rdata);

   logic at_fetch;
   assign at_fetch = (bus_addr == AW'(OFS_FETCH));

   // R2: a reported identifier names a doorbell that is pending and enabled
   assert_fetch_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (at_fetch && bus_rdata != NONE_PENDING) |-> (rd_ok && pend_q[rd_idx] && en_q[rd_idx]));

   // R3: nothing active gives all-ones
   assert_fetch_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (at_fetch && ((pend_q & en_q) == '0)) |-> (bus_rdata == NONE_PENDING));

   // R4: a mask write clears the enable flag
   assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(OFS_MASK) && wr_ok) |=> !en_q[$past(wr_idx)]);

   // R5: an acknowledge with no competing ring clears the pending flag
   assert_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(OFS_ACK) && wr_ok && !(ring_vld && ring_id == bus_wdata))
      |=> !pend_q[$past(wr_idx)]);

   // R7: an out-of-range ring write leaves every pending flag alone
   assert_oor_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(OFS_RING) && !wr_ok && !ring_vld) |=> (pend_q == $past(pend_q)));

   // R8 / R10: a ring input always leaves its doorbell pending
   assert_ring_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_vld && rg_ok) |=> pend_q[$past(rg_idx)]);

   // R9: reset empties both flag sets
   assert_reset_R9: assert property (@(posedge clk)
      !rst_n |=> (pend_q == '0 && en_q == '0));

endmodule

bind db_ctrl db_ctrl_chk #(.NC(NC), .NS(NS), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .ring_vld  (ring_vld),
   .ring_id   (ring_id),
   .pend_q    (pend_q),
   .en_q      (en_q)
);

// File: tb/tb_db_ctrl.sv
module tb_db_ctrl;
   import db_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NC = 4;
   localparam int NS = 12;
   localparam int AW = 8;
   localparam int N  = NC * NS;
   localparam logic [AW-1:0] A_RING  = AW'(OFS_RING);
   localparam logic [AW-1:0] A_FETCH = AW'(OFS_FETCH);
   localparam logic [AW-1:0] A_UNMSK = AW'(OFS_UNMSK);
   localparam logic [AW-1:0] A_MASK  = AW'(OFS_MASK);
   localparam logic [AW-1:0] A_ACK   = AW'(OFS_ACK);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = A_FETCH;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          ring_vld = 1'b0;
   logic [31:0]   ring_id = '0;
   logic          irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   db_ctrl #(.NC(NC), .NS(NS), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ring_vld(ring_vld),
      .ring_id(ring_id), .irq(irq)
   );

   // behavioural reference
   bit mp [N];
   bit me [N];

   function automatic bit ok_id(logic [31:0] w);
      return (w[31:16] < NC) && (w[15:0] < NS);
   endfunction

   function automatic int idx_of(logic [31:0] w);
      return int'(w[31:16]) * NS + int'(w[15:0]);
   endfunction

   function automatic logic [31:0] model_fetch();
      for (int i = 0; i < N; i++)
         if (mp[i] && me[i]) return {16'(i / NS), 16'(i % NS)};
      return 32'hFFFF_FFFF;
   endfunction

   function automatic logic model_irq();
      for (int i = 0; i < N; i++)
         if (mp[i] && me[i]) return 1'b1;
      return 1'b0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            mp[i] = 1'b0;
            me[i] = 1'b0;
         end
      end else begin
         if (bus_wr && ok_id(bus_wdata)) begin
            if (bus_addr == A_ACK)   mp[idx_of(bus_wdata)] = 1'b0;
            if (bus_addr == A_UNMSK) me[idx_of(bus_wdata)] = 1'b1;
            if (bus_addr == A_MASK)  me[idx_of(bus_wdata)] = 1'b0;
            if (bus_addr == A_RING)  mp[idx_of(bus_wdata)] = 1'b1;
         end
         if (ring_vld && ok_id(ring_id)) mp[idx_of(ring_id)] = 1'b1;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R6 irq level", {31'b0, irq}, {31'b0, model_irq()});
         if (bus_addr == A_FETCH) chk("R2 fetch order", bus_rdata, model_fetch());
         else                     chk("R3 other offset", bus_rdata, 32'h0);
      end
   end

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = A_FETCH;
   endtask

   task automatic ring(logic [31:0] d);
      @(posedge clk); #1;
      ring_vld = 1'b1; ring_id = d;
      @(posedge clk); #1;
      ring_vld = 1'b0;
   endtask

   task automatic ring_and_ack(logic [31:0] d);
      @(posedge clk); #1;
      ring_vld = 1'b1; ring_id = d;
      bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = d;
      @(posedge clk); #1;
      ring_vld = 1'b0; bus_wr = 1'b0; bus_addr = A_FETCH;
   endtask

   task automatic expect_fetch(string tag, logic [31:0] exp);
      @(negedge clk);
      chk(tag, bus_rdata, exp);
   endtask

   task automatic expect_irq(string tag, logic exp);
      @(negedge clk);
      chk(tag, {31'b0, irq}, {31'b0, exp});
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      expect_fetch("R9 reset fetch empty", 32'hFFFF_FFFF);
      expect_irq("R9 reset irq low", 1'b0);

      // masked ring is latched
      wr(A_RING, 32'h0001_0003);
      expect_fetch("R4 masked ring hidden", 32'hFFFF_FFFF);
      expect_irq("R4 masked irq low", 1'b0);
      wr(A_UNMSK, 32'h0001_0003);
      expect_fetch("R1 packed identifier", 32'h0001_0003);
      expect_irq("R6 irq high", 1'b1);

      // priority across clients and signals
      wr(A_RING, 32'h0000_0005); wr(A_UNMSK, 32'h0000_0005);
      expect_fetch("R2 lower client first", 32'h0000_0005);
      wr(A_RING, 32'h0001_0001); wr(A_UNMSK, 32'h0001_0001);
      expect_fetch("R2 client beats signal", 32'h0000_0005);
      wr(A_ACK, 32'h0000_0005);
      expect_fetch("R5 ack removes", 32'h0001_0001);
      wr(A_MASK, 32'h0001_0001);
      expect_fetch("R4 mask hides", 32'h0001_0003);
      wr(A_ACK, 32'h0001_0003);
      expect_fetch("R3 empty all ones", 32'hFFFF_FFFF);
      expect_irq("R6 irq drops", 1'b0);
      wr(A_UNMSK, 32'h0001_0001);
      expect_fetch("R4 reported after unmask", 32'h0001_0001);
      wr(A_ACK, 32'h0001_0001);

      // out-of-range identifiers must not alias
      wr(A_UNMSK, 32'h0000_0000);
      wr(A_RING, 32'h0004_0000);
      wr(A_RING, 32'h0000_000C);
      wr(A_RING, 32'h0000_0010);
      wr(A_RING, 32'h0010_0000);
      expect_fetch("R7 out-of-range ring ignored", 32'hFFFF_FFFF);
      wr(A_RING, 32'h0000_0000);
      wr(A_ACK, 32'h0004_0000);
      wr(A_MASK, 32'h0000_0010);
      wr(8'h24, 32'h0000_0000);
      expect_fetch("R7 out-of-range ack and mask ignored", 32'h0000_0000);
      wr(A_ACK, 32'h0000_0000);
      expect_fetch("R5 ack lane 0", 32'hFFFF_FFFF);

      // remote ring and collision
      wr(A_UNMSK, 32'h0002_0007);
      ring(32'h0002_0007);
      expect_fetch("R10 remote ring", 32'h0002_0007);
      ring_and_ack(32'h0002_0007);
      expect_fetch("R8 ring beats ack", 32'h0002_0007);
      wr(A_ACK, 32'h0002_0007);
      expect_fetch("R5 ack after collision", 32'hFFFF_FFFF);

      // drain loop
      wr(A_RING, 32'h0003_000B); wr(A_UNMSK, 32'h0003_000B);
      wr(A_RING, 32'h0000_0000);
      ring(32'h0002_0004);       wr(A_UNMSK, 32'h0002_0004);
      wr(A_RING, 32'h0000_000B); wr(A_UNMSK, 32'h0000_000B);
      expect_fetch("R2 drain step 1", 32'h0000_0000);
      wr(A_ACK, 32'h0000_0000);
      expect_fetch("R2 drain step 2", 32'h0000_000B);
      wr(A_ACK, 32'h0000_000B);
      expect_fetch("R2 drain step 3", 32'h0002_0004);
      wr(A_ACK, 32'h0002_0004);
      expect_fetch("R2 drain step 4", 32'h0003_000B);
      wr(A_ACK, 32'h0003_000B);
      expect_fetch("R3 drained", 32'hFFFF_FFFF);

      // random traffic checked every clock
      for (int k = 0; k < 800; k++) begin
         logic [31:0] d;
         int op;
         @(posedge clk); #1;
         d  = {16'($urandom_range(0, NC)), 16'($urandom_range(0, NS))};
         op = $urandom_range(0, 6);
         ring_vld = ($urandom_range(0, 3) == 0);
         ring_id  = (op == 6) ? d : {16'($urandom_range(0, NC)), 16'($urandom_range(0, NS))};
         bus_wdata = d;
         bus_wr = (op != 5);
         case (op)
            0: bus_addr = A_RING;
            1: bus_addr = A_UNMSK;
            2: bus_addr = A_MASK;
            3, 6: bus_addr = A_ACK;
            4: bus_addr = 8'h04;
            default: bus_addr = A_FETCH;
         endcase
      end
      @(posedge clk); #1;
      bus_wr = 1'b0; ring_vld = 1'b0; bus_addr = A_FETCH;

      // reset in the middle of activity
      wr(A_RING, 32'h0000_0001); wr(A_UNMSK, 32'h0000_0001);
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      expect_fetch("R9 reset clears pending", 32'hFFFF_FFFF);
      expect_irq("R9 reset irq", 1'b0);
      wr(A_RING, 32'h0000_0001);
      expect_fetch("R9 reset clears enable", 32'hFFFF_FFFF);

      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule